// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel I/O Port

This block is an eight-line parallel port that a processor reaches through one bus address. It holds one storage bit per line, and that bit sets both the direction and the value of the line. A stored 0 pulls the line low through an open-drain control. A stored 1 lets go of the line, and a pull-up outside the block raises it unless some other device holds it low. The same storage therefore acts as the output value and as the direction.

A read at the port address returns the level that is really on each line, not the stored bits. The line levels pass through a two-stage synchroniser and are then caught in a read register. Software can use a line as an input by first writing 1 to that bit and then reading the port. The pad buffers and pull-up resistors sit outside the block. The block drives a per-line pull-low enable and takes the pad levels back in.

Top module: `qbio_port`

## Requirements
- R1: While reset is held and right after it is released, `pull_low` is all zeros, so every line is released, and `rdata` is all zeros.
- R2: On a clock edge where `cs` and `wr` are both 1, the storage loads `wdata`, and on that same edge `pull_low` becomes the bitwise inverse of `wdata`.
- R3: A write strobe without `cs`, a `cs` without a write strobe, and any read all leave `pull_low` unchanged.
- R4: A bit written as 0 drives its line low, and reading the port then returns 0 for that bit whatever any external device does.
- R5: A bit written as 1 reads back as 1 when nothing else drives the line, and as 0 when an external device holds the line low.
- R6: `rdata` changes only on a clock edge where `cs` and `rd` are both 1. At any other edge it keeps its value.
- R7: A change on `pin_in` that is set up before clock edge k is first returned by a read strobed at edge k+2. A read strobed at edge k+1 still returns the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Port select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data; 0 pulls the line low, 1 releases it |
| rdata | output | 8 | Line levels captured by the last read |
| pin_in | input | 8 | Levels seen at the pads |
| pull_low | output | 8 | Per-line open-drain enable; 1 drives the line low |

## Verification
The read-path assertion assumes that `pin_in` is the wired result of the block's own `pull_low` and external drivers. It only judges reads made at least four clocks after the internal reset has been released, so that the synchroniser holds post-reset samples. The stimulus builds `pin_in` as a pulled-up open-drain net from `pull_low` and a random external pull-low mask. It changes that mask only at falling clock edges. Random writes and reads are mixed with cycles where the strobes are asserted without select. A directed sequence changes the external mask and reads on the two edges that follow, to pin down the latency.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  parameter int unsigned QB_WIDTH = 8;
  parameter int unsigned QB_SYNC  = 2;

  typedef struct packed {
    logic load;
    logic sample;
  } qb_strobe_t;

  function automatic qb_strobe_t qb_decode(input logic sel, input logic wr, input logic rd);
    qb_strobe_t s;
    s.load   = sel & wr;
    s.sample = sel & rd;
    return s;
  endfunction
endpackage

// File: rtl/qbio_rst_sync.sv
module qbio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/qbio_latch.sv
module qbio_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '1;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb stg_d[0] = async_in;

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_comb stg_d[i] = stg_q[i-1];
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '1;
      else        stg_q[i] <= stg_d[i];
    end
  end

  assign sync_out = stg_q[LAST];
endmodule

// File: rtl/qbio_rdpath.sv
module qbio_rdpath #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] level,
  output logic [W-1:0] rd_q
);
  logic [W-1:0] r_q;
  logic [W-1:0] r_nxt;

  always_comb begin
    r_nxt = r_q;
    if (cap_en) r_nxt = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= r_nxt;
  end

  assign rd_q = r_q;
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int unsigned WIDTH = QB_WIDTH,
  parameter int unsigned SYNC  = QB_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic             rd,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pull_low
);
  logic             rst_n_sync;
  qb_strobe_t       strb;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_sync;

  qbio_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  always_comb strb = qb_decode(cs, wr, rd);

  qbio_latch #(.W(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load_en (strb.load),
    .d       (wdata),
    .q       (latch_q)
  );

  qbio_sync #(.W(WIDTH), .STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  qbio_rdpath #(.W(WIDTH)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cap_en (strb.sample),
    .level  (pin_sync),
    .rd_q   (rdata)
  );

  assign pull_low = ~latch_q;
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic             cs,
  input logic             wr,
  input logic             rd,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pull_low
);
  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)              warm_cnt <= '0;
    else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
  end

  assign warm = (warm_cnt >= 3'd4);

  a_r1_reset_released: assert property (@(posedge clk)
    $rose(srst_n) |-> (pull_low == '0 && rdata == '0));

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!srst_n)
    (cs && wr) |=> (pull_low == ~$past(wdata)));

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!srst_n)
    !(cs && wr) |=> $stable(pull_low));

  a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!srst_n)
    !(cs && rd) |=> $stable(rdata));

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!srst_n)
    (cs && rd && warm) |=> (rdata == $past(pin_in, 3)));
endmodule

bind qbio_port qbio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .srst_n   (rst_n_sync),
  .cs       (cs),
  .wr       (wr),
  .rd       (rd),
  .wdata    (wdata),
  .rdata    (rdata),
  .pin_in   (pin_in),
  .pull_low (pull_low)
);

// File: tb/qbio_port_test.sv
`timescale 1ns/1ps
module qbio_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pull_low;
  logic [W-1:0] ext_low = '0;
  logic [W-1:0] pin_in;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_latch = '1;
  logic done = 1'b0;

  always #10 clk = ~clk;

  // pulled-up open-drain net: low if the block or an external device pulls
  assign pin_in = ~(pull_low | ext_low);

  qbio_port uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pull_low(pull_low)
  );

  function automatic logic [W-1:0] exp_pins(input logic [W-1:0] lat, input logic [W-1:0] ext);
    return lat & ~ext;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] d, input logic sel);
    @(negedge clk); cs = sel; wr = 1'b1; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
    if (sel) exp_latch = d;
  endtask

  task automatic do_read(input logic sel);
    @(negedge clk); cs = sel; rd = 1'b1;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    check("R1 pull_low in reset", pull_low, '0);
    check("R1 rdata in reset", rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pull_low after release", pull_low, '0);
    check("R1 rdata after release", rdata, '0);

    // R5: released, nothing driving
    do_read(1'b1);
    check("R5 idle read", rdata, 8'hFF);

    // R2/R4: write pattern, outputs move on the write edge
    do_write(8'hA5, 1'b1);
    check("R2 pull_low after write", pull_low, 8'h5A);
    settle();
    do_read(1'b1);
    check("R4 driven-low bits read 0", rdata, exp_pins(8'hA5, 8'h00));

    // R5: external device holds released lines low; R4 low bits stay low
    @(negedge clk); ext_low = 8'h0F;
    settle();
    do_read(1'b1);
    check("R5 external low on released bits", rdata, exp_pins(8'hA5, 8'h0F));

    // R3: strobes without select, select without strobe, reads
    do_write(8'h00, 1'b0);
    check("R3 write without cs", pull_low, 8'h5A);
    @(negedge clk); cs = 1'b1; wdata = 8'h33;
    @(negedge clk); cs = 1'b0;
    check("R3 cs without wr", pull_low, 8'h5A);
    do_read(1'b1);
    check("R3 read leaves latch", pull_low, 8'h5A);

    // R6: read strobe without select keeps rdata
    prev = rdata;
    @(negedge clk); ext_low = 8'hF0;
    settle();
    do_read(1'b0);
    check("R6 rd without cs holds", rdata, prev);
    @(negedge clk); cs = 1'b1;
    @(negedge clk); cs = 1'b0;
    check("R6 cs without rd holds", rdata, prev);

    // R7: latency of exactly two edges
    do_write(8'hFF, 1'b1);
    @(negedge clk); ext_low = 8'h00;
    settle();
    @(negedge clk); ext_low = 8'h3C; cs = 1'b1; rd = 1'b1;   // edge k
    @(negedge clk);                                          // after k
    @(negedge clk);                                          // after k+1
    check("R7 read at k+1 old level", rdata, 8'hFF);
    @(negedge clk); cs = 1'b0; rd = 1'b0;                    // after k+2
    check("R7 read at k+2 new level", rdata, 8'hC3);

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] d;
      logic [W-1:0] e;
      logic s;
      d = W'($urandom);
      e = W'($urandom);
      s = ($urandom % 4) != 0;
      do_write(d, s);
      check("R2/R3 random pull_low", pull_low, ~exp_latch);
      @(negedge clk); ext_low = e;
      settle();
      do_read(1'b1);
      check("R4/R5 random read", rdata, exp_pins(exp_latch, e));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule